// File: doc/BRIEF.md
# Receive Frame External Reject Window

This block gives the final accept or reject verdict for each received Ethernet frame. It merges an internal destination-address verdict with a reject strobe from address lookup logic outside the block. The internal verdict combines a physical-address hit, a broadcast flag and a multicast hash bit picked from a 64-bit logical filter. The external strobe only counts while a bit-time window, measured from the start-of-frame delimiter, is open. It must also stay high for a minimum number of system clocks, which stands in for a minimum pulse width in nanoseconds.

The verdict is a registered one-cycle pulse carrying an accept bit. It fires once per frame, when both the frame end and the close of the window have happened. In runt-accept mode the frame end closes the window early. While a frame is in progress, a DMA hold output keeps receive DMA from starting until enough bytes have arrived to reach the receive watermark. It also keeps DMA off for the rest of any frame on which a reject has been latched. The block only works while the run input is high. Dropping run aborts any frame in progress.

Top module: `rx_reject_window`

## Requirements
- R1: The external reject is taken into account only on clock edges where at least 2 and fewer than 512 bit ticks have been counted since the start delimiter was accepted. A qualified reject on any other edge has no effect on the verdict.
- R2: With external reject enabled and promiscuous mode off, a frame that the internal filter passes (or whose internal matching is disabled) is accepted when no qualified reject fell inside its window, and rejected otherwise.
- R3: With promiscuous mode set, every verdict is accept, whatever the reject input and the address hits are.
- R4: Internal matching counts as disabled when promiscuous is 0, no-broadcast is 1, no-physical is 1 and all 64 filter bits are 0. With external reject enabled, only the reject input then decides. With external reject enabled and matching not disabled, a frame with no internal hit is rejected.
- R5: With external reject disabled, the reject input is ignored. The verdict is accept exactly when (physical hit and no-physical is 0), or (broadcast and no-broadcast is 0), or (multicast and filter bit number hash is 1). The hash is 6 bits: bits 5:4 select the 16-bit word and bits 3:0 select the bit within it.
- R6: A reject is qualified only on an edge where the reject input has been high for MIN_CLKS consecutive clocks, counting that edge. A pulse of MIN_CLKS-1 clocks is ignored.
- R7: With runt accept set, the frame-end strobe closes the window. The verdict pulse appears two edges after the edge that samples the frame end. Without runt accept, the verdict comes one edge after the later of two events: the 512th bit tick, and the edge after the frame end is sampled.
- R8: The dec_vld output is a single-cycle pulse, issued exactly once per completed frame, with dec_accept valid alongside it.
- R9: dma_hold is high during a frame until the byte count reaches the watermark. Watermark code 00 means 16 bytes, or 64 bytes when runt accept or full duplex is set. Code 01 means 64 bytes, and codes 10 and 11 mean 128 bytes. Once a reject has been latched, dma_hold stays high until the verdict. dma_hold is low outside frames.
- R10: While run_en is low, no start delimiter is accepted, any frame in progress is dropped without a verdict, and dma_hold is low.
- R11: A start delimiter during a frame restarts the frame. The earlier frame gets no verdict, and its latched reject is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Controller running; low aborts and idles the block |
| sfd_stb | input | 1 | Start-of-frame delimiter strobe |
| bit_tick | input | 1 | One pulse per received bit time |
| rx_byte_stb | input | 1 | One pulse per received byte |
| rx_eof_stb | input | 1 | Frame end strobe |
| ext_rej_in | input | 1 | Reject request from external lookup logic, active high |
| cfg_promisc | input | 1 | Promiscuous mode |
| cfg_ext_rej_en | input | 1 | External reject enable |
| cfg_no_bcast | input | 1 | Disable broadcast acceptance |
| cfg_no_phys | input | 1 | Disable physical address match |
| cfg_runt_ok | input | 1 | Runt accept mode |
| cfg_full_dup | input | 1 | Full-duplex operation |
| cfg_wm_code | input | 2 | Receive watermark code |
| cfg_laf | input | 64 | Logical filter, four 16-bit words |
| hit_phys | input | 1 | Destination equals the station address |
| hit_bcast | input | 1 | Destination is broadcast |
| hit_mcast | input | 1 | Destination is multicast |
| hit_hash | input | 6 | Multicast hash index into cfg_laf |
| dec_vld | output | 1 | Verdict strobe, one per frame |
| dec_accept | output | 1 | Verdict: 1 accept, 0 reject |
| dma_hold | output | 1 | Hold off receive DMA |

## Verification
A bit counter that is one tick off moves the window edge. The fault shows up only for a reject that qualifies right at bit 2 or bit 511, and it turns that verdict around. A miscounting width filter shows up as a wrong verdict for pulses exactly MIN_CLKS or MIN_CLKS-1 long. Stale frame state left over from an aborted or restarted frame shows up as an extra or missing dec_vld pulse within a frame time. A wrong watermark mapping moves the falling edge of dma_hold by whole bytes, and that edge is visible within the first 128 bytes of a frame.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  localparam int WM_BYTE_W = 8;

  typedef enum logic [1:0] {
    WM_SHALLOW = 2'b00,
    WM_MID     = 2'b01,
    WM_DEEP    = 2'b10,
    WM_DEEP_B  = 2'b11
  } wm_code_e;

  // Byte threshold for a watermark code; shallow is promoted when the
  // reject window must be allowed to finish before DMA starts.
  function automatic logic [WM_BYTE_W-1:0] wm_bytes(input logic [1:0] code,
                                                    input logic force_deep);
    case (wm_code_e'(code))
      WM_SHALLOW: return force_deep ? WM_BYTE_W'(64) : WM_BYTE_W'(16);
      WM_MID:     return WM_BYTE_W'(64);
      default:    return WM_BYTE_W'(128);
    endcase
  endfunction

  // Final verdict from its three contributors.
  function automatic logic verdict(input logic promisc, input logic ext_en,
                                   input logic int_off, input logic int_ok,
                                   input logic rejected);
    if (promisc) return 1'b1;
    if (ext_en)  return (int_off || int_ok) && !rejected;
    return int_ok;
  endfunction

endpackage

// File: rtl/rxw_pulse_qual.sv
module rxw_pulse_qual #(
  parameter int MIN_CLKS = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual
);
  localparam int CW = $clog2(MIN_CLKS + 1);
  localparam logic [CW-1:0] SAT   = CW'(MIN_CLKS);
  localparam logic [CW-1:0] NEED1 = CW'(MIN_CLKS - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt <= '0;
    else if (!raw)      run_cnt <= '0;
    else if (run_cnt != SAT) run_cnt <= run_cnt + 1'b1;
  end

  assign qual = raw && (run_cnt >= NEED1);

  generate
    if (MIN_CLKS > 1) begin : g_chk
      // R6: qualification needs the input to have been high before
      a_r6_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> $past(raw));
    end
  endgenerate
endmodule

// File: rtl/rxw_bit_window.sv
module rxw_bit_window #(
  parameter int WIN_LO = 2,
  parameter int WIN_HI = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic tick,
  input  logic early_close,
  output logic win_open,
  output logic win_done
);
  localparam int CNT_W = $clog2(WIN_HI + 1);
  localparam logic [CNT_W-1:0] LO_V = CNT_W'(WIN_LO);
  localparam logic [CNT_W-1:0] HI_V = CNT_W'(WIN_HI);

  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   bit_cnt <= '0;
    else if (restart)                             bit_cnt <= '0;
    else if (active && tick && bit_cnt != HI_V)   bit_cnt <= bit_cnt + 1'b1;
  end

  assign win_done = (bit_cnt == HI_V);
  assign win_open = active && !early_close && (bit_cnt >= LO_V) && !win_done;

  // R1: counter never passes the upper window edge
  a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= HI_V);
  // R1: the window can only be open once ticks have advanced past the start
  a_r1_open_after_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> !win_open);
endmodule

// File: rtl/rxw_addr_filter.sv
module rxw_addr_filter #(
  parameter int LAF_WORDS = 4,
  parameter int LAF_W     = 16,
  localparam int LAF_BITS = LAF_WORDS * LAF_W,
  localparam int HASH_W   = $clog2(LAF_BITS)
) (
  input  logic                cfg_promisc,
  input  logic                cfg_no_bcast,
  input  logic                cfg_no_phys,
  input  logic [LAF_BITS-1:0] cfg_laf,
  input  logic                hit_phys,
  input  logic                hit_bcast,
  input  logic                hit_mcast,
  input  logic [HASH_W-1:0]   hit_hash,
  output logic                int_ok,
  output logic                int_off
);
  logic [LAF_WORDS-1:0] word_zero;

  generate
    for (genvar w = 0; w < LAF_WORDS; w++) begin : g_word
      assign word_zero[w] = (cfg_laf[w*LAF_W +: LAF_W] == '0);
    end
  endgenerate

  assign int_off = !cfg_promisc && cfg_no_bcast && cfg_no_phys && (&word_zero);
  assign int_ok  = (hit_phys  && !cfg_no_phys)  ||
                   (hit_bcast && !cfg_no_bcast) ||
                   (hit_mcast && cfg_laf[hit_hash]);
endmodule

// File: rtl/rxw_dma_gate.sv
module rxw_dma_gate
  import rxw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       active,
  input  logic       byte_stb,
  input  logic       rej_hold,
  input  logic [1:0] wm_code,
  input  logic       force_deep,
  output logic       dma_hold
);
  localparam logic [WM_BYTE_W-1:0] CNT_MAX = '1;

  logic [WM_BYTE_W-1:0] byte_cnt;
  logic [WM_BYTE_W-1:0] thr;

  assign thr = wm_bytes(wm_code, force_deep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         byte_cnt <= '0;
    else if (restart)                                   byte_cnt <= '0;
    else if (active && byte_stb && byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
  end

  assign dma_hold = active && ((byte_cnt < thr) || rej_hold);

  // R9: no watermark lets DMA start before 16 bytes
  a_r9_floor_sixteen: assert property (@(posedge clk) disable iff (!rst_n)
    (active && byte_cnt < WM_BYTE_W'(16)) |-> dma_hold);
  // R9: deep-mode promotion keeps DMA held below 64 bytes
  a_r9_forced_deep: assert property (@(posedge clk) disable iff (!rst_n)
    (active && force_deep && byte_cnt < WM_BYTE_W'(64)) |-> dma_hold);
endmodule

// File: rtl/rx_reject_window.sv
module rx_reject_window
  import rxw_pkg::*;
#(
  parameter int MIN_CLKS  = 28,
  parameter int WIN_LO    = 2,
  parameter int WIN_HI    = 512,
  parameter int LAF_WORDS = 4,
  parameter int LAF_W     = 16,
  localparam int LAF_BITS = LAF_WORDS * LAF_W,
  localparam int HASH_W   = $clog2(LAF_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                sfd_stb,
  input  logic                bit_tick,
  input  logic                rx_byte_stb,
  input  logic                rx_eof_stb,
  input  logic                ext_rej_in,
  input  logic                cfg_promisc,
  input  logic                cfg_ext_rej_en,
  input  logic                cfg_no_bcast,
  input  logic                cfg_no_phys,
  input  logic                cfg_runt_ok,
  input  logic                cfg_full_dup,
  input  logic [1:0]          cfg_wm_code,
  input  logic [LAF_BITS-1:0] cfg_laf,
  input  logic                hit_phys,
  input  logic                hit_bcast,
  input  logic                hit_mcast,
  input  logic [HASH_W-1:0]   hit_hash,
  output logic                dec_vld,
  output logic                dec_accept,
  output logic                dma_hold
);
  logic in_frame, end_seen, rej_seen;
  logic restart, rej_qual, win_open, win_done, early_close;
  logic int_ok, int_off, fin, rej_latch, accept_now;

  assign restart     = run_en && sfd_stb;
  assign early_close = cfg_runt_ok && end_seen;

  rxw_pulse_qual #(.MIN_CLKS(MIN_CLKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .raw(ext_rej_in), .qual(rej_qual)
  );

  rxw_bit_window #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_win (
    .clk(clk), .rst_n(rst_n), .restart(restart), .active(in_frame),
    .tick(bit_tick), .early_close(early_close),
    .win_open(win_open), .win_done(win_done)
  );

  rxw_addr_filter #(.LAF_WORDS(LAF_WORDS), .LAF_W(LAF_W)) u_filt (
    .cfg_promisc(cfg_promisc), .cfg_no_bcast(cfg_no_bcast),
    .cfg_no_phys(cfg_no_phys), .cfg_laf(cfg_laf),
    .hit_phys(hit_phys), .hit_bcast(hit_bcast), .hit_mcast(hit_mcast),
    .hit_hash(hit_hash), .int_ok(int_ok), .int_off(int_off)
  );

  rxw_dma_gate u_gate (
    .clk(clk), .rst_n(rst_n), .restart(restart), .active(in_frame),
    .byte_stb(rx_byte_stb), .rej_hold(rej_seen), .wm_code(cfg_wm_code),
    .force_deep(cfg_runt_ok || cfg_full_dup), .dma_hold(dma_hold)
  );

  assign rej_latch  = cfg_ext_rej_en && !cfg_promisc && win_open && rej_qual;
  assign fin        = in_frame && end_seen && (win_done || cfg_runt_ok);
  assign accept_now = verdict(cfg_promisc, cfg_ext_rej_en, int_off, int_ok, rej_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      end_seen   <= 1'b0;
      rej_seen   <= 1'b0;
      dec_vld    <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_vld <= 1'b0;
      if (!run_en) begin
        in_frame <= 1'b0;
      end else if (sfd_stb) begin
        in_frame <= 1'b1;
        end_seen <= 1'b0;
        rej_seen <= 1'b0;
      end else if (fin) begin
        in_frame   <= 1'b0;
        dec_vld    <= 1'b1;
        dec_accept <= accept_now;
      end else if (in_frame) begin
        end_seen <= end_seen || rx_eof_stb;
        rej_seen <= rej_seen || rej_latch;
      end
    end
  end

  // R1: a reject can only be latched out of an open window
  a_r1_latch_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rej_seen) |-> $past(win_open && rej_qual));
  // R3: promiscuous verdicts are always accept
  a_r3_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && $past(cfg_promisc)) |-> dec_accept);
  // R8: verdict strobe lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);
  // R10: a stopped block issues nothing and holds nothing
  a_r10_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!dec_vld && !dma_hold));
  // R2: a latched reject never yields an accept without promiscuous mode
  a_r2_reject_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rej_seen && !cfg_promisc && run_en && !sfd_stb) |=> !dec_accept);
endmodule

// File: tb/tb_rx_reject_window.sv
module tb_rx_reject_window;
  localparam int MINC = 28;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, run_en, sfd_stb, bit_tick, rx_byte_stb, rx_eof_stb, ext_rej_in;
  logic cfg_promisc, cfg_ext_rej_en, cfg_no_bcast, cfg_no_phys, cfg_runt_ok, cfg_full_dup;
  logic [1:0] cfg_wm_code;
  logic [63:0] cfg_laf;
  logic hit_phys, hit_bcast, hit_mcast;
  logic [5:0] hit_hash;
  logic dec_vld, dec_accept, dma_hold;

  rx_reject_window #(.MIN_CLKS(MINC)) dut (.*);

  int compared = 0, mismatched = 0, cyc = 0;

  // ---------------- behavioural reference model ----------------
  int  m_run, m_bit, m_byte;
  bit  m_in, m_end, m_rej, m_dv, m_da;

  function automatic int thr_of();
    if (cfg_wm_code == 2'b00) return (cfg_runt_ok || cfg_full_dup) ? 64 : 16;
    if (cfg_wm_code == 2'b01) return 64;
    return 128;
  endfunction

  function automatic bit model_accept(bit rej);
    bit off, ok;
    off = !cfg_promisc && cfg_no_bcast && cfg_no_phys && (cfg_laf == 64'd0);
    ok  = (hit_phys && !cfg_no_phys) || (hit_bcast && !cfg_no_bcast) ||
          (hit_mcast && cfg_laf[hit_hash]);
    if (cfg_promisc) return 1'b1;
    if (cfg_ext_rej_en) return (off || ok) && !rej;
    return ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_bit = 0; m_byte = 0;
      m_in = 0; m_end = 0; m_rej = 0; m_dv = 0; m_da = 0;
    end else begin
      bit q, open, fin;
      q    = ext_rej_in && (m_run >= MINC - 1);
      open = m_in && !(cfg_runt_ok && m_end) && m_bit >= 2 && m_bit < 512;
      fin  = m_in && m_end && (m_bit >= 512 || cfg_runt_ok);
      m_run = ext_rej_in ? ((m_run < MINC) ? m_run + 1 : MINC) : 0;
      m_dv = 0;
      if (!run_en) m_in = 0;
      else if (sfd_stb) begin
        m_in = 1; m_bit = 0; m_end = 0; m_rej = 0; m_byte = 0;
      end else if (fin) begin
        m_in = 0; m_dv = 1; m_da = model_accept(m_rej);
      end else if (m_in) begin
        if (bit_tick && m_bit < 512) m_bit++;
        if (rx_byte_stb && m_byte < 255) m_byte++;
        if (rx_eof_stb) m_end = 1;
        if (cfg_ext_rej_en && !cfg_promisc && open && q) m_rej = 1;
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit mh;
      mh = m_in && ((m_byte < thr_of()) || m_rej);
      check(dec_vld == m_dv, "R8", "dec_vld per-cycle", dec_vld, m_dv);
      if (m_dv) check(dec_accept == m_da, "R2", "dec_accept per-cycle", dec_accept, m_da);
      check(dma_hold == mh, "R9", "dma_hold per-cycle", dma_hold, mh);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic set_cfg(bit pr, bit ex, bit nb, bit np, bit ru, bit fd,
                         logic [1:0] wm, logic [63:0] laf);
    @(negedge clk);
    cfg_promisc = pr; cfg_ext_rej_en = ex; cfg_no_bcast = nb; cfg_no_phys = np;
    cfg_runt_ok = ru; cfg_full_dup = fd; cfg_wm_code = wm; cfg_laf = laf;
  endtask

  task automatic set_hits(bit p, bit b, bit m, logic [5:0] h);
    hit_phys = p; hit_bcast = b; hit_mcast = m; hit_hash = h;
  endtask

  // c is the cycle index relative to the start delimiter (c = 0).
  task automatic frame(string tag, int eof_c, int rej_a, int rej_len, int sfd2_c,
                       int stop_c, int exp_ndec, int exp_acc, int exp_dec_c, int exp_rel);
    int last, ndec, acc, dec_c, bytes, rel;
    last = (eof_c > 1024) ? eof_c : 1024;
    if (sfd2_c >= 0 && sfd2_c + 1024 > last) last = sfd2_c + 1024;
    last += 10;
    ndec = 0; acc = -1; dec_c = -1; bytes = 0; rel = -1;
    for (int c = -60; c <= last; c++) begin
      @(negedge clk);
      if (dec_vld) begin ndec++; acc = dec_accept; if (dec_c < 0) dec_c = c; end
      if (c >= 1 && c < eof_c && (stop_c < 0 || c < stop_c) && !dma_hold && rel < 0)
        rel = bytes;
      sfd_stb     = (c == 0) || (c == sfd2_c);
      if (c == sfd2_c) begin bytes = 0; rel = -1; end
      bit_tick    = (c >= 0) && (c % 2 == 1);
      rx_byte_stb = (c >= 0) && (c < eof_c) && (c % 16 == 8);
      if (rx_byte_stb) bytes++;
      rx_eof_stb  = (c == eof_c);
      ext_rej_in  = (c >= rej_a) && (c < rej_a + rej_len);
      run_en      = !(stop_c >= 0 && c >= stop_c);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (dec_vld) begin ndec++; acc = dec_accept; end
      sfd_stb = 0; bit_tick = 0; rx_byte_stb = 0; rx_eof_stb = 0; ext_rej_in = 0;
      run_en = 1;
    end
    check(ndec == exp_ndec, tag, "verdict count", ndec, exp_ndec);
    if (exp_ndec == 1) check(acc == exp_acc, tag, "verdict", acc, exp_acc);
    if (exp_dec_c >= 0) check(dec_c == exp_dec_c, tag, "verdict cycle", dec_c, exp_dec_c);
    if (exp_rel != -2) check(rel == exp_rel, tag, "DMA release byte", rel, exp_rel);
  endtask

  initial begin
    rst_n = 0; run_en = 1; sfd_stb = 0; bit_tick = 0; rx_byte_stb = 0;
    rx_eof_stb = 0; ext_rej_in = 0;
    cfg_promisc = 0; cfg_ext_rej_en = 0; cfg_no_bcast = 0; cfg_no_phys = 0;
    cfg_runt_ok = 0; cfg_full_dup = 0; cfg_wm_code = 2'b01; cfg_laf = '0;
    set_hits(0, 0, 0, 6'd0);
    repeat (4) @(negedge clk);
    check(!dec_vld && !dec_accept && !dma_hold, "R8", "reset outputs",
          {dec_vld, dec_accept, dma_hold}, 0);
    rst_n = 1;

    // external reject only (internal matching disabled)
    set_cfg(0, 1, 1, 1, 0, 0, 2'b01, 64'd0);
    frame("R4", 1200, -1000, 0, -1, -1, 1, 1, 1202, 64);
    frame("R2", 1200, 200, 40, -1, -1, 1, 0, -1, -1);
    frame("R6", 1200, 200, MINC - 1, -1, -1, 1, 1, -1, -2);
    frame("R6", 1200, 200, MINC, -1, -1, 1, 0, -1, -2);
    frame("R1", 1200, -50, 52, -1, -1, 1, 1, -1, -2);   // qualified only before bit 2
    frame("R1", 1200, -50, 60, -1, -1, 1, 0, -1, -2);   // runs into bit 2
    frame("R1", 1200, 990, 34, -1, -1, 1, 0, -1, -2);   // qualifies at bit 511
    frame("R1", 1200, 1030, 40, -1, -1, 1, 1, -1, -2);  // after window
    // internal matching enabled but no hit: rejected even with ext enabled
    set_cfg(0, 1, 1, 1, 0, 0, 2'b01, 64'h1);
    frame("R4", 1200, -1000, 0, -1, -1, 1, 0, -1, -2);

    // promiscuous ignores the reject
    set_cfg(1, 1, 1, 1, 0, 0, 2'b01, 64'd0);
    frame("R3", 1200, 200, 40, -1, -1, 1, 1, -1, 64);

    // external reject disabled: internal filter decides
    set_cfg(0, 0, 0, 0, 0, 0, 2'b01, 64'd0);
    set_hits(1, 0, 0, 6'd0);
    frame("R5", 1200, 200, 40, -1, -1, 1, 1, -1, 64);
    set_cfg(0, 0, 0, 1, 0, 0, 2'b01, 64'd0);
    frame("R5", 1200, -1000, 0, -1, -1, 1, 0, -1, -2);
    set_cfg(0, 0, 0, 1, 0, 0, 2'b01, 64'h0000_0000_0020_0000);   // bit 21
    set_hits(0, 0, 1, 6'd21);
    frame("R5", 1200, -1000, 0, -1, -1, 1, 1, -1, -2);
    set_hits(0, 0, 1, 6'd22);
    frame("R5", 1200, -1000, 0, -1, -1, 1, 0, -1, -2);
    set_hits(0, 1, 0, 6'd0);
    set_cfg(0, 0, 0, 1, 0, 0, 2'b01, 64'd0);
    frame("R5", 1200, -1000, 0, -1, -1, 1, 1, -1, -2);
    set_hits(0, 0, 0, 6'd0);

    // runt accept: frame end closes the window
    set_cfg(0, 1, 1, 1, 1, 0, 2'b01, 64'd0);
    frame("R7", 300, 400, 40, -1, -1, 1, 1, 302, -2);
    frame("R7", 300, 250, 40, -1, -1, 1, 0, 302, -2);
    set_cfg(0, 1, 1, 1, 0, 0, 2'b01, 64'd0);
    frame("R7", 300, 500, 40, -1, -1, 1, 0, 1025, -2);

    // watermark mapping
    set_cfg(0, 1, 1, 1, 0, 0, 2'b00, 64'd0);
    frame("R9", 1200, -1000, 0, -1, -1, 1, 1, -1, 16);
    set_cfg(0, 1, 1, 1, 0, 1, 2'b00, 64'd0);
    frame("R9", 1200, -1000, 0, -1, -1, 1, 1, -1, 64);
    set_cfg(0, 1, 1, 1, 0, 0, 2'b10, 64'd0);
    frame("R9", 2300, -1000, 0, -1, -1, 1, 1, 2302, 128);
    set_cfg(0, 1, 1, 1, 0, 0, 2'b11, 64'd0);
    frame("R9", 2300, -1000, 0, -1, -1, 1, 1, -1, 128);

    // abort and restart
    set_cfg(0, 1, 1, 1, 0, 0, 2'b01, 64'd0);
    frame("R10", 1200, -1000, 0, -1, 500, 0, 0, -1, -2);
    frame("R11", 1500, 100, 40, 300, -1, 1, 1, 1502, -2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule